// File: doc/BRIEF.md
# Dual-Port Burst RAM

This block is a true dual-port synchronous memory. Ports A and B each run on their own clock and reach one shared word array at any time, including the same word. On a rising edge of its clock, each port registers its address, write data and control inputs. Each port holds an address pointer. The pointer can be loaded from the address pins, cleared, stepped by one, or held. A port can therefore make random accesses by loading every cycle, or stream a burst by stepping.

Each port picks its own read latency at run time. The short setting presents read data in the slot that follows the capturing edge. The long setting adds one output register, so the data arrives one clock later. The read output is a valid/data pair with no ready signal. The consumer cannot apply back-pressure and must take each word in the slot where `rvalid` is high. An output-enable input masks the valid flag without a clock.

Word count and width are parameters. The default is 10 address bits, which keeps elaboration small, and the block can be raised to 17 bits. The default width is 9 bits.

Top module: `dp_burst_ram`

## Requirements
- R1: A port is selected only when `en_a_n` is 0 and `en_b` is 1 at the capturing edge. In a deselected cycle the port writes nothing, and its next output slot has `rvalid` at 0.
- R2: When `addr_load_n` is 0 at an edge, and `ptr_clr_n` is 1, the pointer takes `addr`. This takes priority over stepping, and the access in that cycle uses the loaded address.
- R3: When `step_en_n` is 0, and neither clear nor load is active, the pointer advances by one. It wraps from 2^AW-1 to 0.
- R4: When `ptr_clr_n` is 0, the pointer becomes 0. This overrides both load and step.
- R5: When clear, load and step are all 1, the pointer holds its value.
- R6: A selected cycle with `is_read` at 0 stores `wdata` at the pointer address. A read in any later slot returns that word.
- R7: With `lat2` at 0, a selected read captured at edge E drives `rvalid`=1 and the word at the pointer address in the slot right after E.
- R8: With `lat2` at 1, the same read appears one slot later, in the slot after edge E+1. Each port's latency setting is independent of the other port's.
- R9: While `out_en_n` is 1, `rvalid` and `rdata` are 0. Lowering `out_en_n` shows the pending word at once, without a clock edge.
- R10: Both ports can read one word in the same slot. A read on one port in the same slot as a write to that word from the other port returns the old contents.
- R11: If both ports write the same word on clock edges that coincide, port A's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_en_a_n | input | 1 | Port A select term, active low |
| a_en_b | input | 1 | Port A select term, active high |
| a_is_read | input | 1 | Port A: 1 = read, 0 = write |
| a_out_en_n | input | 1 | Port A output enable, active low |
| a_addr_load_n | input | 1 | Port A pointer load from `a_addr`, active low |
| a_step_en_n | input | 1 | Port A pointer step, active low |
| a_ptr_clr_n | input | 1 | Port A pointer clear, active low |
| a_lat2 | input | 1 | Port A: 1 = two-slot read latency |
| a_addr | input | AW | Port A external address |
| a_wdata | input | DW | Port A write data |
| a_rvalid | output | 1 | Port A read word valid |
| a_rdata | output | DW | Port A read word |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_en_a_n | input | 1 | Port B select term, active low |
| b_en_b | input | 1 | Port B select term, active high |
| b_is_read | input | 1 | Port B: 1 = read, 0 = write |
| b_out_en_n | input | 1 | Port B output enable, active low |
| b_addr_load_n | input | 1 | Port B pointer load from `b_addr`, active low |
| b_step_en_n | input | 1 | Port B pointer step, active low |
| b_ptr_clr_n | input | 1 | Port B pointer clear, active low |
| b_lat2 | input | 1 | Port B: 1 = two-slot read latency |
| b_addr | input | AW | Port B external address |
| b_wdata | input | DW | Port B write data |
| b_rvalid | output | 1 | Port B read word valid |
| b_rdata | output | DW | Port B read word |

## Verification
Two pairs of functions can land in the same slot: a write on each port to one word, and a write on one port with a read of that word on the other. Both port clocks run phase-aligned, and both ports are driven in the same slot to provoke these cases. A read issued in the next slot then judges the outcome against a reference array kept by the bench. That array holds the port A value after a collision, and the old word during a cross-port read that overlaps a write. Pointer clear, load and step are also applied together in one cycle, to judge their order of precedence.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_STEP  = 2'd1,
    PTR_LOAD  = 2'd2,
    PTR_CLEAR = 2'd3
  } ptr_op_e;

  typedef enum logic {
    LAT_ONE = 1'b0,
    LAT_TWO = 1'b1
  } lat_mode_e;

  // Clear beats load, load beats step, otherwise hold.
  function automatic ptr_op_e ptr_pick(input logic clr_n, input logic load_n,
                                       input logic step_n);
    if (!clr_n)       return PTR_CLEAR;
    else if (!load_n) return PTR_LOAD;
    else if (!step_n) return PTR_STEP;
    else              return PTR_HOLD;
  endfunction

endpackage

// File: rtl/dpbr_ptr.sv
module dpbr_ptr
  import dpbr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          step_n,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] ptr
);

  ptr_op_e op;
  assign op = ptr_pick(clr_n, load_n, step_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else begin
      unique case (op)
        PTR_CLEAR: ptr <= '0;
        PTR_LOAD:  ptr <= load_addr;
        PTR_STEP:  ptr <= ptr + 1'b1;
        default:   ptr <= ptr;
      endcase
    end
  end

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (ptr == '0)) else $error("pointer not cleared"); // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (ptr == $past(load_addr))) else $error("pointer not loaded"); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n) |=> (ptr == AW'($past(ptr) + 1'b1))) else $error("pointer step"); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && step_n) |=> $stable(ptr)) else $error("pointer moved"); // R5

endmodule

// File: rtl/dpbr_front.sv
module dpbr_front
  import dpbr_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          is_read,
  input  logic          lat2,
  input  logic          addr_load_n,
  input  logic          step_en_n,
  input  logic          ptr_clr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] acc_addr,
  output logic          rd_q,
  output logic          wr_q,
  output logic [DW-1:0] wdata_q,
  output lat_mode_e     mode_q
);

  logic picked;
  assign picked = ~en_a_n & en_b;

  dpbr_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (ptr_clr_n),
    .load_n   (addr_load_n),
    .step_n   (step_en_n),
    .load_addr(addr),
    .ptr      (acc_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      mode_q  <= LAT_ONE;
    end else begin
      rd_q    <= picked & is_read;
      wr_q    <= picked & ~is_read;
      wdata_q <= wdata;
      mode_q  <= lat2 ? LAT_TWO : LAT_ONE;
    end
  end

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_n || !en_b) |=> (!rd_q && !wr_q)) else $error("deselected port active"); // R1

endmodule

// File: rtl/dpbr_xor_store.sv
module dpbr_xor_store #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          a_clk,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  output logic [DW-1:0] a_rdata,
  input  logic          b_clk,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  // Word value = bank_a ^ bank_b; each bank has exactly one writer clock.
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];
  logic          b_yield;

  assign b_yield = a_wr && (a_addr == b_addr);

  always_ff @(posedge a_clk) begin
    if (a_wr) bank_a[a_addr] <= a_data ^ bank_b[a_addr];
  end

  always_ff @(posedge b_clk) begin
    if (b_wr && !b_yield) bank_b[b_addr] <= b_data ^ bank_a[b_addr];
  end

  assign a_rdata = bank_a[a_addr] ^ bank_b[a_addr];
  assign b_rdata = bank_a[b_addr] ^ bank_b[b_addr];

endmodule

// File: rtl/dpbr_rdout.sv
module dpbr_rdout
  import dpbr_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_q,
  input  lat_mode_e     mode_q,
  input  logic [DW-1:0] ram_data,
  input  logic          out_en_n,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);

  logic          pipe_vld;
  logic [DW-1:0] pipe_dat;
  logic          slot_vld;
  logic [DW-1:0] slot_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_vld <= 1'b0;
      pipe_dat <= '0;
    end else begin
      pipe_vld <= rd_q;
      pipe_dat <= ram_data;
    end
  end

  always_comb begin
    if (mode_q == LAT_TWO) begin
      slot_vld = pipe_vld;
      slot_dat = pipe_dat;
    end else begin
      slot_vld = rd_q;
      slot_dat = ram_data;
    end
    rvalid = slot_vld & ~out_en_n;
    rdata  = rvalid ? slot_dat : '0;
  end

  AST_LAT_TWO_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LAT_TWO && rvalid) |-> $past(rd_q)) else $error("late slot without read"); // R8

endmodule

// File: rtl/dp_burst_ram.sv
module dp_burst_ram
  import dpbr_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic          a_en_a_n,
  input  logic          a_en_b,
  input  logic          a_is_read,
  input  logic          a_out_en_n,
  input  logic          a_addr_load_n,
  input  logic          a_step_en_n,
  input  logic          a_ptr_clr_n,
  input  logic          a_lat2,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic          a_rvalid,
  output logic [DW-1:0] a_rdata,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic          b_en_a_n,
  input  logic          b_en_b,
  input  logic          b_is_read,
  input  logic          b_out_en_n,
  input  logic          b_addr_load_n,
  input  logic          b_step_en_n,
  input  logic          b_ptr_clr_n,
  input  logic          b_lat2,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          b_rvalid,
  output logic [DW-1:0] b_rdata
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]         clk_v, rst_v, ena_v, enb_v, rd_in_v, oe_v;
  logic [NPORT-1:0]         ld_v, st_v, cl_v, lat_v;
  logic [NPORT-1:0][AW-1:0] addr_v, acc_v;
  logic [NPORT-1:0][DW-1:0] wd_v, wdq_v, ram_v, rdat_v;
  logic [NPORT-1:0]         rdq_v, wrq_v, rval_v;
  lat_mode_e                mode_v [NPORT];

  assign clk_v   = {b_clk, a_clk};
  assign rst_v   = {b_rst_n, a_rst_n};
  assign ena_v   = {b_en_a_n, a_en_a_n};
  assign enb_v   = {b_en_b, a_en_b};
  assign rd_in_v = {b_is_read, a_is_read};
  assign oe_v    = {b_out_en_n, a_out_en_n};
  assign ld_v    = {b_addr_load_n, a_addr_load_n};
  assign st_v    = {b_step_en_n, a_step_en_n};
  assign cl_v    = {b_ptr_clr_n, a_ptr_clr_n};
  assign lat_v   = {b_lat2, a_lat2};
  assign addr_v  = {b_addr, a_addr};
  assign wd_v    = {b_wdata, a_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpbr_front #(.AW(AW), .DW(DW)) u_front (
      .clk        (clk_v[p]),
      .rst_n      (rst_v[p]),
      .en_a_n     (ena_v[p]),
      .en_b       (enb_v[p]),
      .is_read    (rd_in_v[p]),
      .lat2       (lat_v[p]),
      .addr_load_n(ld_v[p]),
      .step_en_n  (st_v[p]),
      .ptr_clr_n  (cl_v[p]),
      .addr       (addr_v[p]),
      .wdata      (wd_v[p]),
      .acc_addr   (acc_v[p]),
      .rd_q       (rdq_v[p]),
      .wr_q       (wrq_v[p]),
      .wdata_q    (wdq_v[p]),
      .mode_q     (mode_v[p])
    );

    dpbr_rdout #(.DW(DW)) u_rdout (
      .clk     (clk_v[p]),
      .rst_n   (rst_v[p]),
      .rd_q    (rdq_v[p]),
      .mode_q  (mode_v[p]),
      .ram_data(ram_v[p]),
      .out_en_n(oe_v[p]),
      .rvalid  (rval_v[p]),
      .rdata   (rdat_v[p])
    );
  end

  dpbr_xor_store #(.AW(AW), .DW(DW)) u_store (
    .a_clk  (a_clk),
    .a_wr   (wrq_v[0]),
    .a_addr (acc_v[0]),
    .a_data (wdq_v[0]),
    .a_rdata(ram_v[0]),
    .b_clk  (b_clk),
    .b_wr   (wrq_v[1]),
    .b_addr (acc_v[1]),
    .b_data (wdq_v[1]),
    .b_rdata(ram_v[1])
  );

  assign a_rvalid = rval_v[0];
  assign a_rdata  = rdat_v[0];
  assign b_rvalid = rval_v[1];
  assign b_rdata  = rdat_v[1];

endmodule

// File: tb/test_dp_burst_ram.sv
module test_dp_burst_ram;

  localparam int AW    = 10;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int TOP   = DEPTH - 1;

  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_rst_n, b_rst_n;
  logic [1:0] en_a_n, en_b, is_read, out_en_n, load_n, step_n, clr_n, lat2;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic [1:0]    rvalid;
  logic [DW-1:0] rdata [2];

  logic [DW-1:0] model [DEPTH];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 a_clk = ~a_clk;
  always #5 b_clk = ~b_clk;

  dp_burst_ram #(.AW(AW), .DW(DW)) i_dp_burst_ram (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_en_a_n(en_a_n[0]), .a_en_b(en_b[0]),
    .a_is_read(is_read[0]), .a_out_en_n(out_en_n[0]), .a_addr_load_n(load_n[0]),
    .a_step_en_n(step_n[0]), .a_ptr_clr_n(clr_n[0]), .a_lat2(lat2[0]),
    .a_addr(addr[0]), .a_wdata(wdata[0]), .a_rvalid(rvalid[0]), .a_rdata(rdata[0]),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_en_a_n(en_a_n[1]), .b_en_b(en_b[1]),
    .b_is_read(is_read[1]), .b_out_en_n(out_en_n[1]), .b_addr_load_n(load_n[1]),
    .b_step_en_n(step_n[1]), .b_ptr_clr_n(clr_n[1]), .b_lat2(lat2[1]),
    .b_addr(addr[1]), .b_wdata(wdata[1]), .b_rvalid(rvalid[1]), .b_rdata(rdata[1])
  );

  always @(posedge a_clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge a_clk);
    @(negedge a_clk);
  endtask

  task automatic drv(input int p, input bit sel, input bit rd, input bit ld_n,
                     input bit st_n, input bit cl_n, input int a, input int d);
    en_a_n[p]   = !sel;
    en_b[p]     = sel;
    is_read[p]  = rd;
    load_n[p]   = ld_n;
    step_n[p]   = st_n;
    clr_n[p]    = cl_n;
    addr[p]     = AW'(a);
    wdata[p]    = DW'(d);
    out_en_n[p] = 1'b0;
  endtask

  task automatic idle(input int p);
    drv(p, 0, 1, 1, 1, 1, 0, 0);
  endtask

  task automatic wr(input int p, input int a, input int d);
    drv(p, 1, 0, 0, 1, 1, a, d);
    model[a] = DW'(d);
  endtask

  task automatic rd(input int p, input int a);
    drv(p, 1, 1, 0, 1, 1, a, 0);
  endtask

  task automatic t_reset();
    chk("R7 reset a_rvalid", rvalid[0], 0);
    chk("R7 reset b_rvalid", rvalid[1], 0);
    chk("R9 reset a_rdata", rdata[0], 0);
  endtask

  task automatic t_write_flow();
    wr(0, 5, 'h1A5); step();
    wr(0, 6, 'h0C3); step();
    wr(1, 7, 'h111); idle(0); step();
    idle(1); rd(0, 5); step();
    chk("R7 a valid", rvalid[0], 1);
    chk("R6 a data @5", rdata[0], model[5]);
    rd(0, 6); rd(1, 7); step();
    chk("R6 a data @6", rdata[0], model[6]);
    chk("R6 b data @7", rdata[1], model[7]);
    rd(0, 7); rd(1, 5); step();
    chk("R10 a reads B write", rdata[0], model[7]);
    chk("R10 b reads A write", rdata[1], model[5]);
    idle(0); idle(1); step();
    chk("R7 no read no valid", rvalid[0], 0);
  endtask

  task automatic t_pipe();
    lat2[1] = 1'b1; lat2[0] = 1'b0;
    idle(0); idle(1); step();
    rd(0, 5); rd(1, 6); step();
    chk("R8 a one-slot valid", rvalid[0], 1);
    chk("R8 a one-slot data", rdata[0], model[5]);
    chk("R8 b not yet valid", rvalid[1], 0);
    idle(0); rd(1, 7); step();
    chk("R8 b late valid", rvalid[1], 1);
    chk("R8 b late data @6", rdata[1], model[6]);
    chk("R8 a slot over", rvalid[0], 0);
    idle(1); step();
    chk("R8 b back-to-back @7", rdata[1], model[7]);
    step();
    chk("R8 b drained", rvalid[1], 0);
    lat2[1] = 1'b0;
    step();
  endtask

  task automatic t_chip_en();
    wr(0, 20, 'h055); step();
    idle(0); step();
    for (int c = 0; c < 3; c++) begin
      drv(0, 1, 0, 0, 1, 1, 20, 'h1FF);
      en_a_n[0] = (c != 1);
      en_b[0]   = (c == 0);
      step();
      drv(0, 1, 1, 0, 1, 1, 20, 0);
      en_a_n[0] = (c != 1);
      en_b[0]   = (c == 0);
      step();
      chk("R1 deselected read valid", rvalid[0], 0);
    end
    rd(0, 20); step();
    chk("R1 deselected write ignored", rdata[0], 'h055);
    idle(0); step();
  endtask

  task automatic t_counter();
    wr(0, TOP - 1, 'h0E1); step();
    wr(0, TOP, 'h0E2); step();
    wr(0, 0, 'h0E3); step();
    wr(0, 1, 'h0E4); step();
    idle(0); step();
    drv(0, 1, 1, 0, 1, 1, TOP - 1, 0); step();
    chk("R2 load addr", rdata[0], model[TOP - 1]);
    drv(0, 1, 1, 1, 0, 1, 0, 0); step();
    chk("R3 step to top", rdata[0], model[TOP]);
    drv(0, 1, 1, 1, 0, 1, 0, 0); step();
    chk("R3 wrap to zero", rdata[0], model[0]);
    drv(0, 1, 1, 1, 0, 1, 0, 0); step();
    chk("R3 step to one", rdata[0], model[1]);
    drv(0, 1, 1, 1, 1, 1, 0, 0); step();
    chk("R5 hold", rdata[0], model[1]);
    drv(0, 1, 1, 1, 1, 0, 0, 0); step();
    chk("R4 clear", rdata[0], model[0]);
    drv(0, 1, 1, 0, 0, 0, 5, 0); step();
    chk("R4 clear beats load", rdata[0], model[0]);
    drv(0, 1, 1, 0, 0, 1, 5, 0); step();
    chk("R2 load beats step", rdata[0], model[5]);
    idle(0); step();
  endtask

  task automatic t_oe();
    rd(0, 6); out_en_n[0] = 1'b1; step();
    chk("R9 masked valid", rvalid[0], 0);
    chk("R9 masked data", rdata[0], 0);
    out_en_n[0] = 1'b0; #1;
    chk("R9 unmask valid", rvalid[0], 1);
    chk("R9 unmask data", rdata[0], model[6]);
    idle(0); step();
  endtask

  task automatic t_cross();
    logic [DW-1:0] old;
    rd(0, 7); rd(1, 7); step();
    chk("R10 a same word", rdata[0], model[7]);
    chk("R10 b same word", rdata[1], model[7]);
    old = model[7];
    wr(0, 7, 'h07E); rd(1, 7); step();
    chk("R10 b old during A write", rdata[1], old);
    idle(0); rd(1, 7); step();
    chk("R10 b new after A write", rdata[1], model[7]);
    idle(1); step();
  endtask

  task automatic t_collide();
    wr(1, 40, 'h155); wr(0, 40, 'h0AA); step();
    idle(0); idle(1); step();
    rd(1, 40); step();
    chk("R11 port A wins", rdata[1], model[40]);
    wr(0, 41, 'h033); wr(1, 42, 'h0CC); step();
    idle(0); idle(1); step();
    rd(0, 42); rd(1, 41); step();
    chk("R6 A sees B word", rdata[0], model[42]);
    chk("R6 B sees A word", rdata[1], model[41]);
    idle(0); idle(1); step();
  endtask

  initial begin
    a_rst_n = 1'b0; b_rst_n = 1'b0;
    lat2 = 2'b00;
    idle(0); idle(1);
    step(); step();
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    step();
    t_reset();
    t_write_flow();
    t_pipe();
    t_chip_en();
    t_counter();
    t_oe();
    t_cross();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule